// File: doc/BRIEF.md
# Serial Flash Execute-In-Place Read Engine

This block is the master side of a four-line serial flash port. It is used only for memory-mapped reads. A bus client presents an address with a request strobe. The engine then builds one read frame on chip select, the serial clock and four bidirectional data lines. Four bytes come back, packed into one 32-bit word, together with a one-cycle completion pulse. The engine is idle between requests and accepts a new request only while it is idle.

A frame has up to four parts:
- an 8-bit command, always sent on one line;
- an address;
- a dummy stretch;
- the data.

The address and data parts use one, two or four lines, as chosen by a lane-mode input. The dummy stretch drives a confirmation nibble on all four lines during its first serial clock and releases the lines for the rest. The first successful read sets a session flag. While that flag is set, the flash is held in execute-in-place mode, so each later read opens with the address and skips the command. A termination request sends an all-ones address and the termination nibble, with no data part, and then clears the flag.

The serial clock idles low. The engine launches outgoing bits on the falling edge and samples incoming bits on the rising edge. Each serial clock lasts two system clocks.

Top module: `xip_read_engine`

## Requirements
- R1: After synchronous reset the outputs are as follows: `cs_n` is 1, `sclk` is 0, `io_oe` is 0, `req_ready` is 1, `rsp_valid` is 0 and `xip_active` is 0.
- R2: When `xip_active` is 0, a read frame opens with the command byte 0xEB. It is sent most significant bit first on `io_out[0]` over 8 serial clocks, with `io_oe` = 4'b0001.
- R3: The 24-bit address follows the command, or opens the frame when no command is sent. It is sent most significant bit first, taking 24, 12 or 6 serial clocks for `cfg_lanes` = 0 (single), 1 (dual) or 2 (quad). Within each clock the highest-numbered enabled line carries the highest bit, and `io_oe` is 4'b0001, 4'b0011 or 4'b1111 respectively.
- R4: The dummy part lasts 8 serial clocks. In the first of these clocks `io_oe` is 4'b1111 and `io_out` carries `cfg_cont_pat` for a read or `cfg_term_pat` for a termination. In the other 7 clocks `io_oe` is 0.
- R5: Data takes 32/N serial clocks (N = 1, 2 or 4) with `io_oe` = 0. It is sampled on each rising `sclk` edge: from `io_in[1]` in single mode, from `io_in[1:0]` in dual mode and from `io_in[3:0]` in quad mode. The first byte received lands in `rsp_data[7:0]` and the fourth in `rsp_data[31:24]`.
- R6: A completed read frame sets `xip_active`. Every read issued while `xip_active` is 1 omits the command part.
- R7: A request with `req_term` = 1 sends address 0xFFFFFF and the dummy part with the termination nibble, and has no data part. It then clears `xip_active` and completes with `rsp_data` = 0.
- R8: A request strobe presented while `req_ready` is 0 is ignored. It starts no frame and changes no session state.
- R9: While `cs_n` is 1, `sclk` is 0 and `io_oe` is 0. `io_out` and `io_oe` change only while `sclk` is low. Between frames `cs_n` stays high for at least 2 serial clocks (4 system clocks).
- R10: Each frame ends with `rsp_valid` high for exactly one cycle, after `cs_n` has returned high. In that same cycle `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read or termination request strobe |
| req_addr | input | 24 | Flash byte address of the read |
| req_term | input | 1 | Request is a session termination |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Read word, first byte in the low bits |
| cfg_lanes | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| cfg_cont_pat | input | 4 | Continuation nibble for the dummy part |
| cfg_term_pat | input | 4 | Termination nibble for the dummy part |
| xip_active | output | 1 | Execute-in-place session flag |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The bound checker watches the pin-level electrical rules on every cycle:
- the clock stays low and the lines are released whenever chip select is high;
- outputs are stable while the serial clock is high;
- chip select stays high for the minimum gap;
- the completion pulse lasts one cycle and comes only while the engine is idle;
- the session flag changes only outside a frame.

The content of each frame can only be shown by the bench, which replays frames against a flash model and decodes them clock by clock. This covers whether the command is present, the address value and lane mapping, the confirmation nibble, the clock count per phase and the byte order of the returned word, in every lane mode and across session open, continue and close sequences.

// File: rtl/xip_pkg.sv
package xip_pkg;

    localparam int SR_W      = 32;
    localparam int WORD_BITS = 32;
    localparam int CMD_BITS  = 8;

    typedef enum logic [1:0] {
        LANES_1 = 2'd0,
        LANES_2 = 2'd1,
        LANES_4 = 2'd2
    } lanes_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_GAP
    } phase_e;

    typedef struct packed {
        logic            load;
        logic [SR_W-1:0] load_val;
        logic            shift;
        logic            sample;
        lanes_e          lanes;
    } shift_ctl_t;

    function automatic lanes_e to_lanes(input logic [1:0] code);
        case (code)
            2'd0:    return LANES_1;
            2'd1:    return LANES_2;
            default: return LANES_4;
        endcase
    endfunction

    function automatic int lane_count(input lanes_e m);
        case (m)
            LANES_2: return 2;
            LANES_4: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input lanes_e m);
        case (m)
            LANES_2: return 4'b0011;
            LANES_4: return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [31:0] byte_reverse(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/xip_lane_shifter.sv
module xip_lane_shifter
    import xip_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  shift_ctl_t       ctl,
    input  logic [3:0]       io_in,
    output logic [3:0]       tx_lanes,
    output logic [SR_W-1:0]  rx_word
);

    logic [SR_W-1:0] tx_sr;
    logic [SR_W-1:0] rx_sr;
    logic [3:0]      rx_unit;

    // Incoming unit per lane mode: single mode receives on line 1.
    always_comb begin
        case (ctl.lanes)
            LANES_2: rx_unit = {2'b00, io_in[1:0]};
            LANES_4: rx_unit = io_in;
            default: rx_unit = {3'b000, io_in[1]};
        endcase
    end

    // Outgoing unit: top bits of the shift register, MSB on the highest line.
    always_comb begin
        case (ctl.lanes)
            LANES_2: tx_lanes = {2'b00, tx_sr[SR_W-1 -: 2]};
            LANES_4: tx_lanes = tx_sr[SR_W-1 -: 4];
            default: tx_lanes = {3'b000, tx_sr[SR_W-1]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (ctl.load) begin
            tx_sr <= ctl.load_val;
            rx_sr <= '0;
        end else begin
            if (ctl.shift) begin
                tx_sr <= tx_sr << lane_count(ctl.lanes);
            end
            if (ctl.sample) begin
                rx_sr <= (rx_sr << lane_count(ctl.lanes)) | SR_W'(rx_unit);
            end
        end
    end

    assign rx_word = rx_sr;

endmodule

// File: rtl/xip_phase_seq.sv
module xip_phase_seq
    import xip_pkg::*;
#(
    parameter int         ADDR_W       = 24,
    parameter logic [7:0] CMD_CODE     = 8'hEB,
    parameter int         DUMMY_CLKS   = 8,
    parameter int         DUMMY_DRIVEN = 1,
    parameter int         GAP_SCLKS    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_term,
    input  logic [1:0]        cfg_lanes,
    output phase_e            state,
    output logic              ph,
    output logic              drive_pat,
    output logic              is_term,
    output logic              sess,
    output logic              done,
    output lanes_e            mode_q,
    output shift_ctl_t        ctl
);

    localparam int GAP_CYC = 2 * GAP_SCLKS;
    localparam int MAX_A   = (ADDR_W > WORD_BITS) ? ADDR_W : WORD_BITS;
    localparam int MAX_B   = (DUMMY_CLKS > GAP_CYC) ? DUMMY_CLKS : GAP_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_C + 1);

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    int                plen;
    logic              last;
    phase_e            nxt;

    function automatic logic [SR_W-1:0] align_addr(input logic [ADDR_W-1:0] a);
        return SR_W'(a) << (SR_W - ADDR_W);
    endfunction

    // Serial clocks in the current phase (system clocks in the gap).
    always_comb begin
        case (state)
            ST_CMD:   plen = CMD_BITS;
            ST_ADDR:  plen = ADDR_W / lane_count(mode_q);
            ST_DUMMY: plen = DUMMY_CLKS;
            ST_DATA:  plen = WORD_BITS / lane_count(mode_q);
            ST_GAP:   plen = GAP_CYC;
            default:  plen = 1;
        endcase
    end

    assign last = (int'(cnt) == plen - 1);

    always_comb begin
        case (state)
            ST_CMD:   nxt = ST_ADDR;
            ST_ADDR:  nxt = ST_DUMMY;
            ST_DUMMY: nxt = is_term ? ST_GAP : ST_DATA;
            default:  nxt = ST_GAP;
        endcase
    end

    // Shifter control: load on accept and at command-to-address handover,
    // shift on each falling edge inside a phase, sample on each rising edge.
    always_comb begin
        ctl.load     = 1'b0;
        ctl.load_val = '0;
        ctl.lanes    = (state == ST_CMD) ? LANES_1 : mode_q;
        ctl.shift    = ph && !last && (state == ST_CMD || state == ST_ADDR);
        ctl.sample   = !ph && (state == ST_DATA);
        if (state == ST_IDLE && req_valid) begin
            ctl.load = 1'b1;
            if (req_term) begin
                ctl.load_val = align_addr('1);
            end else if (sess) begin
                ctl.load_val = align_addr(req_addr);
            end else begin
                ctl.load_val = SR_W'(CMD_CODE) << (SR_W - CMD_BITS);
            end
        end else if (state == ST_CMD && ph && last) begin
            ctl.load     = 1'b1;
            ctl.load_val = align_addr(addr_q);
        end
    end

    assign drive_pat = (state == ST_DUMMY) && (int'(cnt) < DUMMY_DRIVEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ph      <= 1'b0;
            cnt     <= '0;
            sess    <= 1'b0;
            is_term <= 1'b0;
            mode_q  <= LANES_1;
            addr_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        is_term <= req_term;
                        mode_q  <= to_lanes(cfg_lanes);
                        addr_q  <= req_term ? '1 : req_addr;
                        ph      <= 1'b0;
                        cnt     <= '0;
                        state   <= (req_term || sess) ? ST_ADDR : ST_CMD;
                    end
                end
                ST_GAP: begin
                    if (last) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (last) begin
                            cnt   <= '0;
                            state <= nxt;
                            if (state == ST_DATA) begin
                                sess <= 1'b1;
                            end
                            if (state == ST_DUMMY && is_term) begin
                                sess <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/xip_read_engine.sv
module xip_read_engine
    import xip_pkg::*;
#(
    parameter int         ADDR_W       = 24,
    parameter logic [7:0] CMD_CODE     = 8'hEB,
    parameter int         DUMMY_CLKS   = 8,
    parameter int         DUMMY_DRIVEN = 1,
    parameter int         GAP_SCLKS    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_term,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    input  logic [1:0]        cfg_lanes,
    input  logic [3:0]        cfg_cont_pat,
    input  logic [3:0]        cfg_term_pat,
    output logic              xip_active,
    output logic              cs_n,
    output logic              sclk,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    phase_e          state;
    logic            ph;
    logic            drive_pat;
    logic            is_term;
    logic            sess;
    logic            done;
    lanes_e          mode_q;
    shift_ctl_t      ctl;
    logic [3:0]      tx_lanes;
    logic [SR_W-1:0] rx_word;
    logic            in_frame;

    xip_phase_seq #(
        .ADDR_W       (ADDR_W),
        .CMD_CODE     (CMD_CODE),
        .DUMMY_CLKS   (DUMMY_CLKS),
        .DUMMY_DRIVEN (DUMMY_DRIVEN),
        .GAP_SCLKS    (GAP_SCLKS)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_term  (req_term),
        .cfg_lanes (cfg_lanes),
        .state     (state),
        .ph        (ph),
        .drive_pat (drive_pat),
        .is_term   (is_term),
        .sess      (sess),
        .done      (done),
        .mode_q    (mode_q),
        .ctl       (ctl)
    );

    xip_lane_shifter shift_i (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .io_in    (io_in),
        .tx_lanes (tx_lanes),
        .rx_word  (rx_word)
    );

    assign in_frame = (state == ST_CMD) || (state == ST_ADDR) ||
                      (state == ST_DUMMY) || (state == ST_DATA);

    assign cs_n = !in_frame;
    assign sclk = in_frame && ph;

    always_comb begin
        case (state)
            ST_CMD:   io_oe = 4'b0001;
            ST_ADDR:  io_oe = lane_mask(mode_q);
            ST_DUMMY: io_oe = drive_pat ? 4'b1111 : 4'b0000;
            default:  io_oe = 4'b0000;
        endcase
    end

    assign io_out = drive_pat ? (is_term ? cfg_term_pat : cfg_cont_pat)
                              : (tx_lanes & io_oe);

    assign req_ready  = (state == ST_IDLE);
    assign rsp_valid  = done;
    assign rsp_data   = byte_reverse(rx_word);
    assign xip_active = sess;

endmodule

// File: rtl/xip_read_engine_chk.sv
module xip_read_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic [3:0] io_out,
    input logic [3:0] io_oe,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       xip_active
);

    logic [3:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= 4'hF;
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 4'hF) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R9
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R9
    lines_released_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'b0000));

    // R9
    launch_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> ($stable(io_out) && $stable(io_oe)));

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_cnt >= 4'd4));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (cs_n && req_ready));

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cs_n);

    // R6
    session_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(xip_active) |-> cs_n);

endmodule

bind xip_read_engine xip_read_engine_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .io_out     (io_out),
    .io_oe      (io_oe),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .xip_active (xip_active)
);

// File: tb/xip_read_engine_tb_top.sv
module xip_read_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_term = 1'b0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  cfg_lanes = 2'd0;
    logic [3:0]  cfg_cont_pat = 4'hA;
    logic [3:0]  cfg_term_pat = 4'hF;
    logic        xip_active;
    logic        cs_n;
    logic        sclk;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;
    logic [3:0]  io_in;

    int checks = 0;
    int errors = 0;

    // flash model and monitor state
    int          rises = 0;
    int          data_start = 0;
    int          data_clks = 0;
    int          cur_n = 1;
    logic [31:0] stream = '0;
    logic [3:0]  rec_out [0:79];
    logic [3:0]  rec_oe  [0:79];
    logic        prev_cs = 1'b1;
    logic        prev_sclk = 1'b0;
    logic        prev_rv = 1'b0;
    int          hi_run = 100;
    int          gap_bad = 0;
    int          idle_bad = 0;
    int          dbl_bad = 0;
    bit          exp_sess = 1'b0;

    always #4 clk = ~clk;

    xip_read_engine dut_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_term     (req_term),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .cfg_lanes    (cfg_lanes),
        .cfg_cont_pat (cfg_cont_pat),
        .cfg_term_pat (cfg_term_pat),
        .xip_active   (xip_active),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .io_out       (io_out),
        .io_oe        (io_oe),
        .io_in        (io_in)
    );

    function automatic logic [31:0] stream_of(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [3:0] mask_of(input int n);
        return (n == 1) ? 4'b0001 : ((n == 2) ? 4'b0011 : 4'b1111);
    endfunction

    // Flash model: presents data unit j while the low half before rise j lasts.
    always_comb begin
        io_in = 4'b0000;
        if (data_clks > 0 && rises >= data_start && rises < data_start + data_clks) begin
            int j;
            logic [31:0] u;
            j = rises - data_start;
            u = (stream >> (32 - (j + 1) * cur_n)) & 32'(mask_of(cur_n));
            if (cur_n == 1) io_in = {2'b00, u[0], 1'b0};
            else            io_in = u[3:0];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n && prev_cs) begin
                rises = 0;
                if (hi_run < 4) gap_bad++;
            end
            if (cs_n) hi_run++;
            else      hi_run = 0;
            if (cs_n && (sclk || io_oe != 4'b0000)) idle_bad++;
            if (!cs_n && sclk && !prev_sclk) begin
                if (rises < 80) begin
                    rec_out[rises] = io_out;
                    rec_oe[rises]  = io_oe;
                end
                rises++;
            end
            if (rsp_valid && prev_rv) dbl_bad++;
            prev_cs   = cs_n;
            prev_sclk = sclk;
            prev_rv   = rsp_valid;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input int mode, input logic [23:0] addr, input bit term,
                             input logic [31:0] word, input bit poke);
        int          n;
        int          aclk;
        int          base;
        int          t;
        bit          has_cmd;
        bit          ok;
        logic [3:0]  m;
        logic [7:0]  cv;
        logic [23:0] av;
        logic [23:0] expa;
        logic [31:0] got;
        n       = (mode == 0) ? 1 : ((mode == 1) ? 2 : 4);
        aclk    = 24 / n;
        m       = mask_of(n);
        has_cmd = !term && !exp_sess;
        expa    = term ? 24'hFFFFFF : addr;
        cfg_lanes  = mode[1:0];
        cur_n      = n;
        data_start = (has_cmd ? 8 : 0) + aclk + 8;
        data_clks  = term ? 0 : 32 / n;
        stream     = stream_of(word);

        t = 0;
        while (!req_ready && t < 2000) begin @(negedge clk); t++; end
        req_valid = 1'b1; req_addr = addr; req_term = term;
        @(negedge clk);
        req_valid = 1'b0; req_term = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            req_valid = 1'b1; req_term = 1'b1; req_addr = 24'h000055;
            repeat (3) @(negedge clk);
            req_valid = 1'b0; req_term = 1'b0;
        end
        t = 0;
        while (!rsp_valid && t < 3000) begin @(negedge clk); t++; end
        chk(rsp_valid && req_ready && cs_n, "R10 completion pulse with engine idle",
            {29'd0, rsp_valid, req_ready, cs_n}, 32'h7);
        got = rsp_data;

        base = 0;
        if (has_cmd) begin
            cv = '0; ok = 1'b1;
            for (int k = 0; k < 8; k++) begin
                cv = {cv[6:0], rec_out[k][0]};
                if (rec_oe[k] != 4'b0001) ok = 1'b0;
            end
            chk(ok && cv == 8'hEB, "R2 command byte", {24'd0, cv}, 32'hEB);
            base = 8;
        end
        av = '0; ok = 1'b1;
        for (int k = 0; k < aclk; k++) begin
            av = (av << n) | 24'(rec_out[base + k] & m);
            if (rec_oe[base + k] != m) ok = 1'b0;
        end
        chk(ok && av == expa, term ? "R7 termination address" : "R3 address bits",
            {8'd0, av}, {8'd0, expa});

        base = base + aclk;
        ok = (rec_oe[base] == 4'b1111) &&
             (rec_out[base] == (term ? cfg_term_pat : cfg_cont_pat));
        for (int k = 1; k < 8; k++) begin
            if (rec_oe[base + k] != 4'b0000) ok = 1'b0;
        end
        chk(ok, "R4 dummy confirmation nibble", {24'd0, rec_oe[base], rec_out[base]},
            {24'd0, 4'hF, term ? cfg_term_pat : cfg_cont_pat});

        ok = 1'b1;
        for (int k = data_start; k < data_start + data_clks && k < 80; k++) begin
            if (rec_oe[k] != 4'b0000) ok = 1'b0;
        end
        chk(ok && rises == data_start + data_clks, "R5 frame clock count",
            32'(rises), 32'(data_start + data_clks));

        if (term) chk(got == 32'd0, "R7 termination word", got, 32'd0);
        else      chk(got == word,  "R5 read word byte order", got, word);

        exp_sess = !term;
        chk(xip_active == exp_sess, term ? "R7 session cleared" : "R6 session set",
            {31'd0, xip_active}, {31'd0, exp_sess});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lowc;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && !sclk && io_oe == 0 && req_ready && !rsp_valid && !xip_active,
            "R1 reset state",
            {26'd0, cs_n, sclk, |io_oe, req_ready, rsp_valid, xip_active}, 32'h24);

        // R2 R3 R6: first quad read carries the command
        run_frame(2, 24'h123456, 1'b0, 32'hDDCCBBAA, 1'b0);
        // R8: requests while busy are ignored, R6 no command
        run_frame(2, 24'hABCDEF, 1'b0, 32'h01020304, 1'b1);
        lowc = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!cs_n) lowc++;
        end
        chk(lowc == 0 && xip_active, "R8 busy request ignored", 32'(lowc), 32'd0);
        // R3 single and dual, boundary addresses
        run_frame(0, 24'h000000, 1'b0, 32'h80000001, 1'b0);
        run_frame(1, 24'hFFFFFF, 1'b0, 32'h5A5AA5A5, 1'b0);
        // R7 termination, then the command returns
        run_frame(2, 24'h000000, 1'b1, 32'h0, 1'b0);
        run_frame(0, 24'h0F0F0F, 1'b0, 32'hCAFEF00D, 1'b0);
        cfg_cont_pat = 4'h5;
        cfg_term_pat = 4'h9;
        run_frame(1, 24'h333333, 1'b0, 32'h12345678, 1'b0);
        run_frame(1, 24'h000000, 1'b1, 32'h0, 1'b0);
        cfg_cont_pat = 4'hA;
        cfg_term_pat = 4'hF;

        for (int i = 0; i < 24; i++) begin
            int  md;
            bit  tm;
            md = int'($urandom % 3);
            tm = ($urandom % 5) == 0;
            run_frame(md, 24'($urandom), tm, $urandom, 1'b0);
        end

        // R9 per-cycle observations collected by the monitor
        chk(gap_bad == 0, "R9 chip select gap", 32'(gap_bad), 32'd0);
        chk(idle_bad == 0, "R9 idle clock and lines", 32'(idle_bad), 32'd0);
        chk(dbl_bad == 0, "R10 single cycle pulse", 32'(dbl_bad), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule